// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a write-back, write-allocate data cache for a processor load/store port. The primary store is direct mapped. A small fully associative victim buffer sits behind it and keeps the last few lines that the primary store threw out. When a request misses the primary store, the victim buffer is searched on the following cycle. A line found there is swapped back into the primary store, and the line it displaces takes the freed slot. The next level is not touched. Only when both structures miss does the block fetch the whole line over its next-level port.

The victim buffer replaces its entries in insertion order, using a wrapping slot pointer. An entry pushed out of the buffer is written to the next level only if it is dirty. A clean entry pushed out is dropped. The processor port handles one request at a time: `cpu_req_ready` falls while a miss is being served and rises again on the cycle the response is presented. The next-level port moves one full line per request. Its read data returns on `mem_resp_valid`, and writes have no response.

Default geometry: 32-bit byte addresses, 32-bit words, 4 words per line, 64 primary sets and 4 victim entries. Address bits [3:2] select the word, bits [9:4] select the set and bits [31:10] form the tag. Victim entries hold the full 28-bit line address.

Top module: `l1_victim_cache`

## Requirements
- R1: During and after reset, `cpu_resp_valid` and `mem_req_valid` are low and `cpu_req_ready` is high. All primary and victim lines are invalid, so the first access to any line is a next-level fetch.
- R2: A request that hits the primary store gets `cpu_resp_valid` one cycle after the accepting edge and causes no next-level request.
- R3: A write updates only the addressed 32-bit word. A later read of that word returns the last value written, whichever of the primary store, the victim buffer or the next level holds it at that time.
- R4: When a valid line is replaced in the primary store by a next-level fill, it is written into the victim slot under the insertion pointer, and the 2-bit pointer advances by one. The victim buffer never matches one address in two slots.
- R5: A primary miss that hits the victim buffer responds two cycles after the accepting edge. It makes no next-level request. The displaced primary line takes the victim slot that was hit.
- R6: A miss in both structures issues exactly one next-level read for the line, with address bits [3:0] zero, and responds after the line has returned.
- R7: Before a fill, if the slot under the insertion pointer holds a dirty line, that line is written to the next level, making exactly one write request. A clean line in that slot causes no write.
- R8: `cpu_req_ready` stays low from the edge that accepts a missing request until the response cycle. `cpu_resp_valid` is a single-cycle pulse, and next-level requests appear only while the processor port is stalled.
- R9: A next-level request that is not yet accepted keeps `mem_req_valid`, `mem_req_we` and `mem_req_addr` unchanged until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Block can take a request this cycle |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address (word aligned) |
| cpu_req_wdata | input | 32 | Store data |
| cpu_resp_valid | output | 1 | Response pulse for the accepted request |
| cpu_resp_rdata | output | 32 | Load data |
| mem_req_valid | output | 1 | Next-level request present |
| mem_req_ready | input | 1 | Next level takes the request this cycle |
| mem_req_we | output | 1 | 1 = line write, 0 = line read |
| mem_req_addr | output | 32 | Line byte address, low 4 bits zero |
| mem_req_wdata | output | 128 | Line data for a write |
| mem_resp_valid | input | 1 | Read line returned |
| mem_resp_rdata | input | 128 | Returned line, word 0 in the low bits |

## Verification
Each result has a fixed due cycle, counted from the rising edge that accepts the request. A primary hit responds one cycle later and a victim hit two cycles later. A double miss responds one cycle after the edge that captures `mem_resp_valid`, following one next-level read and, if the pushed-out entry was dirty, one write before it. The bench drives inputs and samples every output on falling edges. It counts falling edges from acceptance until the response pulse, then compares that count, the next-level read and write counts over the request, and the returned word against a flat word model that it updates on every store. Its next-level model always holds each request one cycle before accepting it. That gap is used to confirm that the request stays stable and that the processor port stays stalled throughout.

// File: rtl/l1_victim_cache_pkg.sv
// Package: shared controller state encoding for the victim-backed data cache.
// Assumes: nothing beyond SystemVerilog enums.
package l1_victim_cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // accepting requests, primary lookup
        ST_VBCHK = 3'd1,   // primary missed, victim buffer searched
        ST_WBACK = 3'd2,   // dirty pushed-out entry sent to next level
        ST_FREQ  = 3'd3,   // next-level line read requested
        ST_FWAIT = 3'd4    // waiting for next-level line to return
    } vc_state_t;

endpackage

// File: rtl/l1vc_line_store.sv
// Module: direct-mapped primary line store. Combinational read of one set,
// one synchronous write per cycle. Valid and dirty bits reset; tags and data
// do not, because a line with its valid bit clear is never trusted.
// Assumes: SETS is a power of two.
module l1vc_line_store #(
    parameter int SETS   = 64,
    parameter int TAG_W  = 22,
    parameter int LINE_W = 128,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              wr_dirty
);

    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_q [SETS];

    // Present the addressed set to the controller.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_dirty = dirty_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_line  = line_q[rd_idx];
    end

    // Per-set status bits, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    // Tag and data arrays, written without reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            line_q[wr_idx] <= wr_line;
        end
    end

endmodule

// File: rtl/l1vc_victim_buf.sv
// Module: fully associative victim buffer. Compares a line address against
// every entry at once and reports the matching slot. It also exposes the
// entry under an insertion pointer that advances in insertion order.
// Assumes: DEPTH is a power of two (pointer wraps naturally); the controller
// never inserts an address that is already present.
module l1vc_victim_buf #(
    parameter int DEPTH  = 4,
    parameter int LA_W   = 28,
    parameter int LINE_W = 128,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LA_W-1:0]   look_addr,
    output logic              hit,
    output logic [PTR_W-1:0]  hit_slot,
    output logic [DEPTH-1:0]  hit_vec,
    output logic [LINE_W-1:0] hit_line,
    output logic              hit_dirty,
    output logic [PTR_W-1:0]  head_slot,
    output logic              head_valid,
    output logic              head_dirty,
    output logic [LA_W-1:0]   head_addr,
    output logic [LINE_W-1:0] head_line,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_slot,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [LA_W-1:0]   wr_addr,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              adv
);

    logic [DEPTH-1:0]  valid_q;
    logic [DEPTH-1:0]  dirty_q;
    logic [LA_W-1:0]   addr_q [DEPTH];
    logic [LINE_W-1:0] line_q [DEPTH];
    logic [PTR_W-1:0]  ptr_q;

    // One comparator per entry.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = valid_q[i] && (addr_q[i] == look_addr);
    end

    // Encode the matching slot and select its contents.
    always_comb begin
        hit       = |hit_vec;
        hit_slot  = '0;
        hit_line  = '0;
        hit_dirty = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) begin
                hit_slot  = PTR_W'(i);
                hit_line  = line_q[i];
                hit_dirty = dirty_q[i];
            end
        end
    end

    // Expose the entry that the next insertion will overwrite.
    always_comb begin
        head_slot  = ptr_q;
        head_valid = valid_q[ptr_q];
        head_dirty = dirty_q[ptr_q];
        head_addr  = addr_q[ptr_q];
        head_line  = line_q[ptr_q];
    end

    // Status bits and insertion pointer, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            ptr_q   <= '0;
        end else begin
            if (wr_en) begin
                valid_q[wr_slot] <= wr_valid;
                dirty_q[wr_slot] <= wr_dirty;
            end
            if (adv) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    // Entry address and data storage.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            addr_q[wr_slot] <= wr_addr;
            line_q[wr_slot] <= wr_line;
        end
    end

endmodule

// File: rtl/l1vc_line_merge.sv
// Module: splices a store word into a line and extracts the addressed word.
// Assumes: WORDS is a power of two.
module l1vc_line_merge #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    localparam int WSEL_W = $clog2(WORDS),
    localparam int LINE_W = DATA_W * WORDS
) (
    input  logic [LINE_W-1:0] line_in,
    input  logic [WSEL_W-1:0] wsel,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [LINE_W-1:0] line_out,
    output logic [DATA_W-1:0] word_out
);

    // Replace only the selected word when storing.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign line_out[w*DATA_W +: DATA_W] =
            (we && (wsel == WSEL_W'(w))) ? wdata : line_in[w*DATA_W +: DATA_W];
    end

    // Word returned to the processor.
    assign word_out = line_in[wsel*DATA_W +: DATA_W];

endmodule

// File: rtl/l1_victim_cache.sv
// Module: top of the victim-backed data cache. Holds the request register,
// the miss-handling state machine and the response register, and wires the
// primary store, victim buffer and word merge together.
// Assumes: word-aligned requests; one request in flight; the next level
// returns a read line some time after accepting the request, and writes
// need no response.
module l1_victim_cache #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int WORDS    = 4,
    parameter int SETS     = 64,
    parameter int VB_DEPTH = 4,
    localparam int LINE_W  = DATA_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0] mem_req_wdata,
    input  logic              mem_resp_valid,
    input  logic [LINE_W-1:0] mem_resp_rdata
);
    import l1_victim_cache_pkg::*;

    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int OFF_W  = BYTE_W + WSEL_W;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LA_W   = ADDR_W - OFF_W;
    localparam int PTR_W  = $clog2(VB_DEPTH);

    vc_state_t         state_q, state_d;
    logic              rq_we;
    logic [ADDR_W-1:0] rq_addr;
    logic [DATA_W-1:0] rq_wdata;
    logic              cap_req;
    logic              resp_d;

    logic              cur_we;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic [WSEL_W-1:0] cur_wsel;

    logic              l1_rd_valid, l1_rd_dirty, l1_hit;
    logic [TAG_W-1:0]  l1_rd_tag;
    logic [LINE_W-1:0] l1_rd_line;
    logic              l1_wr_en, l1_wr_dirty;

    logic              vb_hit, vb_hit_dirty;
    logic [PTR_W-1:0]  vb_hit_slot, vb_head_slot;
    logic [VB_DEPTH-1:0] vb_hit_vec;
    logic [LINE_W-1:0] vb_hit_line, vb_head_line;
    logic              vb_head_valid, vb_head_dirty;
    logic [LA_W-1:0]   vb_head_addr;
    logic              vb_wr_en, vb_wr_valid, vb_wr_dirty, vb_adv;
    logic [PTR_W-1:0]  vb_wr_slot;
    logic [LA_W-1:0]   vb_wr_addr;
    logic [LINE_W-1:0] vb_wr_line;

    logic [LINE_W-1:0] base_line, merged_line;
    logic [DATA_W-1:0] base_word;

    // Use the live request while idle, the captured one while serving a miss.
    always_comb begin
        if (state_q == ST_IDLE) begin
            cur_we    = cpu_req_we;
            cur_addr  = cpu_req_addr;
            cur_wdata = cpu_req_wdata;
        end else begin
            cur_we    = rq_we;
            cur_addr  = rq_addr;
            cur_wdata = rq_wdata;
        end
        cur_wsel = cur_addr[BYTE_W +: WSEL_W];
        cur_idx  = cur_addr[OFF_W +: IDX_W];
        cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
    end

    l1vc_line_store #(
        .SETS   (SETS),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (cur_idx),
        .rd_valid (l1_rd_valid),
        .rd_dirty (l1_rd_dirty),
        .rd_tag   (l1_rd_tag),
        .rd_line  (l1_rd_line),
        .wr_en    (l1_wr_en),
        .wr_idx   (cur_idx),
        .wr_tag   (cur_tag),
        .wr_line  (merged_line),
        .wr_dirty (l1_wr_dirty)
    );

    assign l1_hit = l1_rd_valid && (l1_rd_tag == cur_tag);

    l1vc_victim_buf #(
        .DEPTH  (VB_DEPTH),
        .LA_W   (LA_W),
        .LINE_W (LINE_W)
    ) u_vbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_addr  (rq_addr[ADDR_W-1:OFF_W]),
        .hit        (vb_hit),
        .hit_slot   (vb_hit_slot),
        .hit_vec    (vb_hit_vec),
        .hit_line   (vb_hit_line),
        .hit_dirty  (vb_hit_dirty),
        .head_slot  (vb_head_slot),
        .head_valid (vb_head_valid),
        .head_dirty (vb_head_dirty),
        .head_addr  (vb_head_addr),
        .head_line  (vb_head_line),
        .wr_en      (vb_wr_en),
        .wr_slot    (vb_wr_slot),
        .wr_valid   (vb_wr_valid),
        .wr_dirty   (vb_wr_dirty),
        .wr_addr    (vb_wr_addr),
        .wr_line    (vb_wr_line),
        .adv        (vb_adv)
    );

    // Pick the line that is about to land in the primary store.
    always_comb begin
        case (state_q)
            ST_VBCHK: base_line = vb_hit_line;
            ST_FWAIT: base_line = mem_resp_rdata;
            default:  base_line = l1_rd_line;
        endcase
    end

    l1vc_line_merge #(
        .DATA_W (DATA_W),
        .WORDS  (WORDS)
    ) u_merge (
        .line_in  (base_line),
        .wsel     (cur_wsel),
        .we       (cur_we),
        .wdata    (cur_wdata),
        .line_out (merged_line),
        .word_out (base_word)
    );

    // Next-state and per-state write strobes for both stores.
    always_comb begin
        state_d     = state_q;
        cap_req     = 1'b0;
        resp_d      = 1'b0;
        l1_wr_en    = 1'b0;
        l1_wr_dirty = 1'b0;
        vb_wr_en    = 1'b0;
        vb_wr_slot  = vb_head_slot;
        vb_wr_valid = 1'b1;
        vb_wr_dirty = l1_rd_dirty;
        vb_wr_addr  = {l1_rd_tag, cur_idx};
        vb_wr_line  = l1_rd_line;
        vb_adv      = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cpu_req_valid) begin
                    if (l1_hit) begin
                        resp_d      = 1'b1;
                        l1_wr_en    = cur_we;
                        l1_wr_dirty = 1'b1;
                    end else begin
                        cap_req = 1'b1;
                        state_d = ST_VBCHK;
                    end
                end
            end
            ST_VBCHK: begin
                if (vb_hit) begin
                    l1_wr_en    = 1'b1;
                    l1_wr_dirty = vb_hit_dirty | rq_we;
                    vb_wr_en    = 1'b1;
                    vb_wr_slot  = vb_hit_slot;
                    vb_wr_valid = l1_rd_valid;
                    resp_d      = 1'b1;
                    state_d     = ST_IDLE;
                end else if (vb_head_valid && vb_head_dirty) begin
                    state_d = ST_WBACK;
                end else begin
                    state_d = ST_FREQ;
                end
            end
            ST_WBACK: begin
                if (mem_req_ready) begin
                    vb_wr_en    = 1'b1;
                    vb_wr_dirty = 1'b0;
                    vb_wr_addr  = vb_head_addr;
                    vb_wr_line  = vb_head_line;
                    state_d     = ST_FREQ;
                end
            end
            ST_FREQ: begin
                if (mem_req_ready) begin
                    state_d = ST_FWAIT;
                end
            end
            ST_FWAIT: begin
                if (mem_resp_valid) begin
                    l1_wr_en    = 1'b1;
                    l1_wr_dirty = rq_we;
                    vb_wr_en    = l1_rd_valid;
                    vb_adv      = l1_rd_valid;
                    resp_d      = 1'b1;
                    state_d     = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Controller state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture a missing request for the duration of its service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_we    <= 1'b0;
            rq_addr  <= '0;
            rq_wdata <= '0;
        end else if (cap_req) begin
            rq_we    <= cpu_req_we;
            rq_addr  <= cpu_req_addr;
            rq_wdata <= cpu_req_wdata;
        end
    end

    // Registered response pulse and load data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_resp_valid <= 1'b0;
            cpu_resp_rdata <= '0;
        end else begin
            cpu_resp_valid <= resp_d;
            if (resp_d) begin
                cpu_resp_rdata <= base_word;
            end
        end
    end

    // Processor and next-level port outputs decoded from state.
    assign cpu_req_ready = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_WBACK) || (state_q == ST_FREQ);
    assign mem_req_we    = (state_q == ST_WBACK);
    assign mem_req_addr  = (state_q == ST_WBACK) ? {vb_head_addr, {OFF_W{1'b0}}}
                                                 : {rq_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mem_req_wdata = vb_head_line;

endmodule

// File: rtl/l1_victim_cache_chk.sv
// Module: protocol checker for the victim-backed data cache, bound to the top.
// Assumes: synchronous active-low reset on rst_n.
module l1_victim_cache_chk #(
    parameter int ADDR_W   = 32,
    parameter int VB_DEPTH = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cpu_req_valid,
    input logic                cpu_req_ready,
    input logic                cpu_resp_valid,
    input logic                mem_req_valid,
    input logic                mem_req_ready,
    input logic                mem_req_we,
    input logic [ADDR_W-1:0]   mem_req_addr,
    input logic [VB_DEPTH-1:0] vb_hit_vec
);

    // Reset leaves both request and response strobes low.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!cpu_resp_valid && !mem_req_valid));

    // An accepted request either answers next cycle or stalls the port.
    assert_hit_or_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready) |=> (cpu_resp_valid || !cpu_req_ready));

    // No line address sits in two victim slots.
    assert_victim_unique_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vb_hit_vec));

    // Responses only appear once the port is free again.
    assert_resp_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |-> cpu_req_ready);

    // Next-level traffic only while the processor is stalled.
    assert_mem_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !cpu_req_ready);

    // A waiting next-level request holds its command and address.
    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

endmodule

bind l1_victim_cache l1_victim_cache_chk #(
    .ADDR_W   (ADDR_W),
    .VB_DEPTH (VB_DEPTH)
) u_chk (.*);

// File: tb/sim_l1_victim_cache.sv
`timescale 1ns/1ps
// Bench: walks a table of accesses on one conflicting set plus one other set,
// compares data with a flat word model, then runs directed reset checks.
module sim_l1_victim_cache;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LINE_W = 128;
    localparam int NLINES = 1024;
    localparam int NVEC   = 20;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cpu_req_valid;
    logic              cpu_req_ready;
    logic              cpu_req_we;
    logic [ADDR_W-1:0] cpu_req_addr;
    logic [DATA_W-1:0] cpu_req_wdata;
    logic              cpu_resp_valid;
    logic [DATA_W-1:0] cpu_resp_rdata;
    logic              mem_req_valid;
    logic              mem_req_ready;
    logic              mem_req_we;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [LINE_W-1:0] mem_req_wdata;
    logic              mem_resp_valid;
    logic [LINE_W-1:0] mem_resp_rdata;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;

    logic [LINE_W-1:0] mem_arr [NLINES];
    logic [DATA_W-1:0] ref_w   [NLINES*4];

    always #4 clk = ~clk;

    l1_victim_cache u0 (.*);

    // Pass/fail bookkeeping for one comparison.
    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] seed_word(input int i);
        return {16'hC0DE, 16'(i)};
    endfunction

    // Next-level model: holds each request one cycle, then accepts it;
    // a read returns its line two falling edges after acceptance.
    int                  pend = 0;
    int                  pend_line = 0;
    bit                  held = 1'b0;
    logic [ADDR_W-1:0]   held_addr;
    logic                held_we;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_req_ready  = 1'b0;
            mem_resp_valid = 1'b0;
            pend = 0;
            held = 1'b0;
        end else begin
            mem_resp_valid = 1'b0;
            mem_req_ready  = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    mem_resp_valid = 1'b1;
                    mem_resp_rdata = mem_arr[pend_line];
                end
            end
            if (held) begin
                chk(mem_req_valid && mem_req_addr == held_addr && mem_req_we == held_we,
                    "R9 held request unchanged", mem_req_addr, held_addr);
                held = 1'b0;
                mem_req_ready = 1'b1;
                chk(mem_req_addr[3:0] == 4'h0, "R6 line-aligned address",
                    {28'h0, mem_req_addr[3:0]}, 32'h0);
                if (mem_req_we) begin
                    mem_arr[mem_req_addr[13:4]] = mem_req_wdata;
                    wr_cnt++;
                end else begin
                    rd_cnt++;
                    pend_line = int'(mem_req_addr[13:4]);
                    pend = 2;
                end
            end else if (mem_req_valid) begin
                held = 1'b1;
                held_addr = mem_req_addr;
                held_we = mem_req_we;
            end
        end
    end

    // Watchdog: a hung run is a failure but still reports the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // One processor access; returns data, latency in falling edges after the
    // accepting edge, and whether the port stayed stalled while waiting.
    task automatic access(input logic we, input logic [31:0] addr,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output int lat, output bit stall_ok, output bit pulse_ok);
        int guard;
        cpu_req_valid = 1'b1;
        cpu_req_we    = we;
        cpu_req_addr  = addr;
        cpu_req_wdata = wd;
        guard = 0;
        while (!cpu_req_ready && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        cpu_req_valid = 1'b0;
        lat = 1;
        stall_ok = 1'b1;
        while (!cpu_resp_valid && lat < 200) begin
            if (cpu_req_ready) stall_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        rd = cpu_resp_rdata;
        @(negedge clk);
        pulse_ok = !cpu_resp_valid;
    endtask

    // Stimulus table: {we, addr[15:0], wdata, kind(0 hit,1 victim,2 fill), wb}
    localparam logic [51:0] VEC [NVEC] = '{
        {1'b0, 16'h0000, 32'h0,         2'd2, 1'b0},
        {1'b0, 16'h0004, 32'h0,         2'd0, 1'b0},
        {1'b1, 16'h0008, 32'h1111AAAA,  2'd0, 1'b0},
        {1'b0, 16'h0008, 32'h0,         2'd0, 1'b0},
        {1'b0, 16'h0400, 32'h0,         2'd2, 1'b0},
        {1'b0, 16'h0008, 32'h0,         2'd1, 1'b0},
        {1'b0, 16'h0800, 32'h0,         2'd2, 1'b0},
        {1'b0, 16'h0C00, 32'h0,         2'd2, 1'b0},
        {1'b0, 16'h1000, 32'h0,         2'd2, 1'b0},
        {1'b1, 16'h1000, 32'h2222BBBB,  2'd0, 1'b0},
        {1'b0, 16'h1400, 32'h0,         2'd2, 1'b0},
        {1'b0, 16'h0000, 32'h0,         2'd1, 1'b0},
        {1'b0, 16'h0408, 32'h0,         2'd2, 1'b0},
        {1'b0, 16'h1800, 32'h0,         2'd2, 1'b0},
        {1'b0, 16'h1C00, 32'h0,         2'd2, 1'b0},
        {1'b0, 16'h2000, 32'h0,         2'd2, 1'b1},
        {1'b0, 16'h1000, 32'h0,         2'd2, 1'b1},
        {1'b0, 16'h0008, 32'h0,         2'd2, 1'b0},
        {1'b1, 16'h0014, 32'h3333CCCC,  2'd2, 1'b0},
        {1'b0, 16'h0014, 32'h0,         2'd0, 1'b0}
    };

    initial begin
        logic [31:0] rd;
        int lat;
        bit stall_ok, pulse_ok;
        int rd0, wr0;

        rst_n = 1'b0;
        cpu_req_valid = 1'b0;
        cpu_req_we = 1'b0;
        cpu_req_addr = '0;
        cpu_req_wdata = '0;
        mem_req_ready = 1'b0;
        mem_resp_valid = 1'b0;
        mem_resp_rdata = '0;
        for (int l = 0; l < NLINES; l++) begin
            for (int w = 0; w < 4; w++) begin
                mem_arr[l][w*32 +: 32] = seed_word(l*4 + w);
                ref_w[l*4 + w] = seed_word(l*4 + w);
            end
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(cpu_req_ready, "R1 ready after reset", {31'h0, cpu_req_ready}, 32'h1);
        chk(!cpu_resp_valid, "R1 no response after reset", {31'h0, cpu_resp_valid}, 32'h0);
        chk(!mem_req_valid, "R1 no next-level request after reset", {31'h0, mem_req_valid}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            logic        v_we;
            logic [31:0] v_addr, v_wd;
            logic [1:0]  v_kind;
            logic        v_wb;
            v_we   = VEC[i][51];
            v_addr = {16'h0, VEC[i][50:35]};
            v_wd   = VEC[i][34:3];
            v_kind = VEC[i][2:1];
            v_wb   = VEC[i][0];
            rd0 = rd_cnt;
            wr0 = wr_cnt;
            access(v_we, v_addr, v_wd, rd, lat, stall_ok, pulse_ok);
            if (!v_we) begin
                // R3: read returns latest stored word
                chk(rd == ref_w[v_addr[13:2]], "R3 read data", rd, ref_w[v_addr[13:2]]);
            end else begin
                ref_w[v_addr[13:2]] = v_wd;
            end
            // R8: single-cycle response pulse
            chk(pulse_ok, "R8 response pulse width", {31'h0, pulse_ok}, 32'h1);
            case (v_kind)
                2'd0: begin
                    chk(lat == 1, "R2 hit latency", lat, 1);
                    chk(rd_cnt == rd0 && wr_cnt == wr0, "R2 no next-level traffic on hit",
                        rd_cnt - rd0 + wr_cnt - wr0, 0);
                end
                2'd1: begin
                    chk(lat == 2, "R5 victim hit latency", lat, 2);
                    chk(rd_cnt == rd0, "R4 line served from victim slot", rd_cnt - rd0, 0);
                    chk(stall_ok, "R8 stalled during victim swap", {31'h0, stall_ok}, 32'h1);
                end
                default: begin
                    chk(rd_cnt - rd0 == 1, "R6 one line read on double miss", rd_cnt - rd0, 1);
                    chk(stall_ok, "R8 stalled during fill", {31'h0, stall_ok}, 32'h1);
                end
            endcase
            chk(wr_cnt - wr0 == int'(v_wb), "R7 write-back count", wr_cnt - wr0, {31'h0, v_wb});
        end

        // R1: a fresh reset discards all cached lines; stored data survives
        // only in the next level (0x0008 was written back earlier).
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_req_ready && !cpu_resp_valid && !mem_req_valid, "R1 idle after second reset",
            {29'h0, cpu_req_ready, cpu_resp_valid, mem_req_valid}, 32'h4);
        rd0 = rd_cnt;
        access(1'b0, 32'h0000_0008, 32'h0, rd, lat, stall_ok, pulse_ok);
        chk(rd_cnt - rd0 == 1, "R1 cache empty after reset", rd_cnt - rd0, 1);
        chk(rd == 32'h1111AAAA, "R3 stored word kept in next level", rd, 32'h1111AAAA);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule